// File: doc/BRIEF.md
# Doorbell Request Mailbox

This block is a small register window that a host processor uses to hand requests to a management controller. The host first loads request words into a staging buffer. It then writes a command word, which starts the request: the block marks itself busy and sends the controller a one-cycle doorbell. The controller reads the staged words through its own port and places any reply bytes in a response buffer. It then strobes completion with an error flag and an 8-bit error code.

The command word carries an opcode, a request id, a payload size and a notify bit. The request id, together with an initiator id sampled from the host side, is copied into a read-only status word that the host can poll. If the notify bit was set in the launching command, completion also raises a one-cycle interrupt to the host, so the host need not poll. The host reads reply data from the response buffer either as whole words or as single bytes.

Top module: `doorbell_mailbox`

## Requirements
- R1: After reset, busy, error, error code, request id, initiator id, both buffers and the latched command word read as zero, and neither the doorbell nor the host interrupt is asserted.
- R2: A host write to byte offset 0x00 while idle sets busy on the next clock edge. On that same edge it asserts the doorbell for exactly one cycle and presents the written word on the controller's command output.
- R3: A read at offset 0x04 returns the status word: bit 0 busy, bit 1 error, bits 7:4 the request id (bits 15:12 of the launching command), bits 15:8 the initiator id sampled at launch, bits 23:16 the error code, all other bits zero.
- R4: A write to offset 0x00 while busy is ignored: it raises no doorbell and changes neither the command output nor any status field.
- R5: Host word writes at 0x80 + 4*i load staging word i, which the controller reads by index. Host reads anywhere in the staging region return zero.
- R6: Controller writes load response word i, which the host reads at 0x90 + 4*i. With the byte-read input high, the read returns byte (address bits 1:0) of that word in bits 7:0, with the upper bits zero.
- R7: A completion strobe while busy clears busy and latches the error flag and error code on the same edge. A completion strobe while idle changes nothing, and busy stays at 1 until a completion arrives.
- R8: If the notify bit (bit 8) was set in the launching command, the host interrupt is a one-cycle pulse on the edge where busy clears. If that bit was clear, no interrupt is issued.
- R9: Reads of the command offset 0x00 return zero, and host writes into the response region have no effect.
- R10: Launching a new command clears the error flag and error code left by the previous request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | ADDR_W | Host byte address |
| hostWrData | input | 32 | Host write data |
| hostByteRd | input | 1 | Selects a byte-wide read of the response buffer |
| hostInitId | input | 8 | Initiator id sampled when a command launches |
| hostRdData | output | 32 | Host read data (combinational from address) |
| hostIrq | output | 1 | Completion interrupt pulse to the host |
| doorbell | output | 1 | One-cycle request pulse to the controller |
| ctlCommand | output | 32 | Command word latched at launch |
| ctlWbIdx | input | log2(WB_WORDS) | Controller staging-word index |
| ctlWbData | output | 32 | Staging word at ctlWbIdx |
| ctlRbWrEn | input | 1 | Controller response write strobe |
| ctlRbIdx | input | log2(RB_WORDS) | Controller response-word index |
| ctlRbData | input | 32 | Controller response data |
| ctlDone | input | 1 | Completion strobe |
| ctlErr | input | 1 | Error flag carried with completion |
| ctlErrCode | input | 8 | Error code carried with completion |

## Verification
On every cycle, the assertions enforce the protocol invariants. A doorbell only appears while busy, and a host interrupt only on the edge where busy falls, lasting one cycle. Busy never drops without a completion strobe. The latched command stays frozen while busy, and the error fields move only at a launch or a completion. The bench scenarios are needed for the data-carrying behaviour: the exact status word layout, the staging and response contents seen through each port, byte extraction, the absence of an interrupt when notify is clear, and clearing of a stale error on relaunch.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // word offsets (byte offset / 4) of the host-visible regions
  localparam int CMD_WORD    = 0;
  localparam int STATUS_WORD = 1;
  localparam int WB_BASE_WORD = 32;  // 0x80
  localparam int RB_BASE_WORD = 36;  // 0x90
  localparam int NOTIFY_BIT  = 8;

  typedef struct packed {
    logic launch;  // accepted command write
    logic finish;  // accepted completion
  } mboxStrobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              notifyReq,
  input  logic              ctlDone,
  output mboxStrobe_t       strobe,
  output logic              busy,
  output logic              doorbell,
  output logic              hostIrq
);
  logic cmdHit;
  logic notifyQ;

  assign cmdHit = hostWrEn && (int'(hostAddr[ADDR_W-1:2]) == CMD_WORD);

  always_comb begin
    strobe.launch = cmdHit && !busy;
    strobe.finish = ctlDone && busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      doorbell <= 1'b0;
      hostIrq  <= 1'b0;
      notifyQ  <= 1'b0;
    end else begin
      doorbell <= strobe.launch;
      hostIrq  <= strobe.finish && notifyQ;
      if (strobe.launch) begin
        busy    <= 1'b1;
        notifyQ <= notifyReq;
      end else if (strobe.finish) begin
        busy <= 1'b0;
      end
    end
  end

  AST_BELL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    doorbell |-> busy); // R2
  AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdHit) |=> !doorbell); // R4
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && !$past(ctlDone)) |-> busy); // R7
  AST_IRQ_AT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> (!busy && $past(busy))); // R8
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |=> !hostIrq); // R8
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int WB_WORDS = 4,
  parameter int RB_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  mboxStrobe_t                 strobe,
  input  logic                        busy,
  input  logic                        hostWrEn,
  input  logic [ADDR_W-1:0]           hostAddr,
  input  logic [31:0]                 hostWrData,
  input  logic                        hostByteRd,
  input  logic [7:0]                  hostInitId,
  output logic [31:0]                 hostRdData,
  output logic [31:0]                 ctlCommand,
  input  logic [$clog2(WB_WORDS)-1:0] ctlWbIdx,
  output logic [31:0]                 ctlWbData,
  input  logic                        ctlRbWrEn,
  input  logic [$clog2(RB_WORDS)-1:0] ctlRbIdx,
  input  logic [31:0]                 ctlRbData,
  input  logic                        ctlErr,
  input  logic [7:0]                  ctlErrCode
);
  localparam int WB_IDX_W = $clog2(WB_WORDS);
  localparam int RB_IDX_W = $clog2(RB_WORDS);

  logic [31:0] wbMem [WB_WORDS];
  logic [31:0] rbMem [RB_WORDS];
  logic [31:0] cmdWord;
  logic [7:0]  initId;
  logic        errQ;
  logic [7:0]  codeQ;

  logic [ADDR_W-3:0]   wordAddr;
  logic                wbSel, rbSel, statusSel;
  logic [WB_IDX_W-1:0] wbHostIdx;
  logic [RB_IDX_W-1:0] rbHostIdx;
  logic [31:0]         rbWord;

  assign wordAddr  = hostAddr[ADDR_W-1:2];
  assign statusSel = int'(wordAddr) == STATUS_WORD;
  assign wbSel     = int'(wordAddr) >= WB_BASE_WORD && int'(wordAddr) < WB_BASE_WORD + WB_WORDS;
  assign rbSel     = int'(wordAddr) >= RB_BASE_WORD && int'(wordAddr) < RB_BASE_WORD + RB_WORDS;
  assign wbHostIdx = WB_IDX_W'(int'(wordAddr) - WB_BASE_WORD);
  assign rbHostIdx = RB_IDX_W'(int'(wordAddr) - RB_BASE_WORD);

  // staging buffer: host writes, controller reads
  for (genvar i = 0; i < WB_WORDS; i++) begin : gWb
    always_ff @(posedge clk) begin
      if (!rstN) wbMem[i] <= '0;
      else if (hostWrEn && wbSel && wbHostIdx == WB_IDX_W'(i)) wbMem[i] <= hostWrData;
    end
  end

  // response buffer: controller writes, host reads
  for (genvar i = 0; i < RB_WORDS; i++) begin : gRb
    always_ff @(posedge clk) begin
      if (!rstN) rbMem[i] <= '0;
      else if (ctlRbWrEn && ctlRbIdx == RB_IDX_W'(i)) rbMem[i] <= ctlRbData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdWord <= '0;
      initId  <= '0;
      errQ    <= 1'b0;
      codeQ   <= '0;
    end else if (strobe.launch) begin
      cmdWord <= hostWrData;
      initId  <= hostInitId;
      errQ    <= 1'b0;
      codeQ   <= '0;
    end else if (strobe.finish) begin
      errQ  <= ctlErr;
      codeQ <= ctlErrCode;
    end
  end

  assign ctlCommand = cmdWord;
  assign ctlWbData  = wbMem[ctlWbIdx];
  assign rbWord     = rbMem[rbHostIdx];

  always_comb begin
    hostRdData = '0;
    if (statusSel) begin
      hostRdData = {8'h00, codeQ, initId, cmdWord[15:12], 2'b00, errQ, busy};
    end else if (rbSel) begin
      if (hostByteRd) hostRdData = {24'h0, rbWord[{hostAddr[1:0], 3'b000} +: 8]};
      else            hostRdData = rbWord;
    end
  end

  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> $stable(cmdWord)); // R4
  AST_CODE_MOVES_ON_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(codeQ) |-> $past(strobe.launch || strobe.finish)); // R7
  AST_ERR_CLEAR_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.launch |=> !errQ); // R10
endmodule

// File: rtl/doorbell_mailbox.sv
module doorbell_mailbox
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int WB_WORDS = 4,
  parameter int RB_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        hostWrEn,
  input  logic [ADDR_W-1:0]           hostAddr,
  input  logic [31:0]                 hostWrData,
  input  logic                        hostByteRd,
  input  logic [7:0]                  hostInitId,
  output logic [31:0]                 hostRdData,
  output logic                        hostIrq,
  output logic                        doorbell,
  output logic [31:0]                 ctlCommand,
  input  logic [$clog2(WB_WORDS)-1:0] ctlWbIdx,
  output logic [31:0]                 ctlWbData,
  input  logic                        ctlRbWrEn,
  input  logic [$clog2(RB_WORDS)-1:0] ctlRbIdx,
  input  logic [31:0]                 ctlRbData,
  input  logic                        ctlDone,
  input  logic                        ctlErr,
  input  logic [7:0]                  ctlErrCode
);
  mboxStrobe_t strobe;
  logic        busy;

  mbox_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostWrEn  (hostWrEn),
    .hostAddr  (hostAddr),
    .notifyReq (hostWrData[NOTIFY_BIT]),
    .ctlDone   (ctlDone),
    .strobe    (strobe),
    .busy      (busy),
    .doorbell  (doorbell),
    .hostIrq   (hostIrq)
  );

  mbox_datapath #(.ADDR_W(ADDR_W), .WB_WORDS(WB_WORDS), .RB_WORDS(RB_WORDS)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busy       (busy),
    .hostWrEn   (hostWrEn),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .hostByteRd (hostByteRd),
    .hostInitId (hostInitId),
    .hostRdData (hostRdData),
    .ctlCommand (ctlCommand),
    .ctlWbIdx   (ctlWbIdx),
    .ctlWbData  (ctlWbData),
    .ctlRbWrEn  (ctlRbWrEn),
    .ctlRbIdx   (ctlRbIdx),
    .ctlRbData  (ctlRbData),
    .ctlErr     (ctlErr),
    .ctlErrCode (ctlErrCode)
  );
endmodule

// File: tb/test_doorbell_mailbox.sv
module test_doorbell_mailbox;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic        hostByteRd = 1'b0;
  logic [7:0]  hostInitId = '0;
  logic [31:0] hostRdData;
  logic        hostIrq, doorbell;
  logic [31:0] ctlCommand, ctlWbData;
  logic [1:0]  ctlWbIdx = '0;
  logic        ctlRbWrEn = 1'b0;
  logic [1:0]  ctlRbIdx = '0;
  logic [31:0] ctlRbData = '0;
  logic        ctlDone = 1'b0, ctlErr = 1'b0;
  logic [7:0]  ctlErrCode = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  doorbell_mailbox i_doorbell_mailbox (.*);

  // independent reference model of the register view
  logic [31:0] mWb [4];
  logic [31:0] mRb [4];
  logic [31:0] mCmd = '0;
  logic [7:0]  mInit = '0, mCode = '0;
  logic        mBusy = 0, mErr = 0, mNotify = 0, mDb = 0, mIrq = 0;

  typedef struct {
    logic [31:0] rd, wb, cmd;
    logic        db, irq;
    string       tag;
  } item_t;
  item_t sb[$];

  int checks = 0, errors = 0;
  bit finished = 0;

  function automatic logic [31:0] modelRead(logic [7:0] a, logic b);
    logic [31:0] w;
    if (a[7:2] == 6'd1) return {8'h00, mCode, mInit, mCmd[15:12], 2'b00, mErr, mBusy};
    if (a >= 8'h90 && a < 8'hA0) begin
      w = mRb[a[3:2]];
      if (b) return {24'h0, w[8*a[1:0] +: 8]};
      return w;
    end
    return 32'h0;
  endfunction

  // driver: push expectation for the upcoming edge, then advance one cycle
  task automatic step(string tag);
    item_t it;
    it.rd = modelRead(hostAddr, hostByteRd);
    it.wb = mWb[ctlWbIdx];
    it.cmd = mCmd;
    it.db = mDb;
    it.irq = mIrq;
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    hostWrEn = 0; ctlDone = 0; ctlRbWrEn = 0; hostByteRd = 0;
    mDb = 0; mIrq = 0;
  endtask

  task automatic hostWrite(logic [7:0] a, logic [31:0] d, string tag);
    hostWrEn = 1; hostAddr = a; hostWrData = d;
    if (a[7:2] == 6'd0 && !mBusy) begin
      mBusy = 1; mCmd = d; mInit = hostInitId; mNotify = d[8];
      mErr = 0; mCode = 0; mDb = 1;
    end else if (a >= 8'h80 && a < 8'h90) begin
      mWb[a[3:2]] = d;
    end
    step(tag);
  endtask

  task automatic hostRead(logic [7:0] a, logic b, string tag);
    hostAddr = a; hostByteRd = b;
    step(tag);
  endtask

  task automatic ctlFinish(logic e, logic [7:0] c, string tag);
    ctlDone = 1; ctlErr = e; ctlErrCode = c; hostAddr = 8'h04;
    if (mBusy) begin
      mBusy = 0; mErr = e; mCode = c; mIrq = mNotify;
    end
    step(tag);
  endtask

  task automatic ctlFill(logic [1:0] i, logic [31:0] d, string tag);
    ctlRbWrEn = 1; ctlRbIdx = i; ctlRbData = d;
    mRb[i] = d;
    step(tag);
  endtask

  // monitor: compare the scoreboard head after each edge
  always @(posedge clk) begin
    item_t it;
    #2;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      checks++;
      if (hostRdData !== it.rd || ctlWbData !== it.wb || ctlCommand !== it.cmd ||
          doorbell !== it.db || hostIrq !== it.irq) begin
        errors++;
        $display("FAIL %s rd=%h/%h wb=%h/%h cmd=%h/%h bell=%b/%b irq=%b/%b (actual/expected)",
                 it.tag, hostRdData, it.rd, ctlWbData, it.wb, ctlCommand, it.cmd,
                 doorbell, it.db, hostIrq, it.irq);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mWb[i] = '0; mRb[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    hostRead(8'h04, 0, "R1 status after reset");
    hostRead(8'h90, 0, "R1 response after reset");
    // R5: staging buffer
    hostWrite(8'h80, 32'h11223344, "R5 stage word0");
    hostWrite(8'h84, 32'hCAFEF00D, "R5 stage word1");
    ctlWbIdx = 2'd1;
    hostRead(8'h84, 0, "R5 ctl reads word1, host read is zero");
    ctlWbIdx = 2'd0;
    hostRead(8'h80, 0, "R5 ctl reads word0");
    // R2: launch with notify set, id 5
    hostInitId = 8'h5A;
    hostWrite(8'h00, 32'h000351A7, "R2 launch notify");
    hostRead(8'h04, 0, "R3 status while busy");
    // R4: relaunch while busy ignored
    hostInitId = 8'hC3;
    hostWrite(8'h00, 32'h0000F0FF, "R4 write while busy");
    hostRead(8'h04, 0, "R4 status unchanged");
    // R6 / R9: response buffer
    ctlFill(2'd0, 32'h44332211, "R6 fill word0");
    ctlFill(2'd1, 32'h88776655, "R6 fill word1");
    hostWrite(8'h94, 32'hDEADBEEF, "R9 host write to response ignored");
    hostRead(8'h94, 0, "R9 response word1 intact");
    hostRead(8'h04, 0, "R7 busy still held");
    // R7 / R8: completion with error, notify pulse
    ctlFinish(1'b1, 8'h3C, "R8 irq on completion");
    hostRead(8'h04, 0, "R7 status after completion");
    hostRead(8'h90, 0, "R6 word read");
    hostRead(8'h95, 1, "R6 byte read");
    hostRead(8'h93, 1, "R6 top byte read");
    hostRead(8'h00, 0, "R9 command offset reads zero");
    // R7: completion while idle ignored
    ctlFinish(1'b0, 8'h77, "R7 idle completion ignored");
    hostRead(8'h04, 0, "R7 status kept");
    // R10 / R8: relaunch without notify
    hostInitId = 8'h21;
    hostWrite(8'h00, 32'h00012022, "R10 relaunch no notify");
    hostRead(8'h04, 0, "R10 error cleared on launch");
    ctlFinish(1'b0, 8'h00, "R8 no irq when notify clear");
    hostRead(8'h04, 0, "R3 final status");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule